// File: doc/BRIEF.md
# Watchdog Timer With Protected Control Register

This block is the watchdog of a small 8-bit microcontroller. A free-running up-counter runs on its own slow clock, which is unrelated to the system clock. If software does not restart the counter before it rolls over from all ones, the block drives a system reset pulse. Software controls the watchdog through an 8-bit register window on the system bus. A control register holds the run enable and a restart strobe, and a status register holds a sticky flag that records a watchdog-caused reset.

A timed-access unlock guards the control register, so runaway code cannot switch the watchdog off or restart it by chance. Two key bytes must reach the key register on back-to-back bus cycles. One control write is then accepted within the next few system clocks. The run enable leaves the system domain as a level through a two-flop synchronizer. It also drives the oscillator enable. The restart strobe crosses as a toggle. The overflow event comes back as a toggle and is stretched into a reset pulse. Every reset drops the run enable, whether it is the external power-on reset or the watchdog's own pulse.

Register map (byte registers, 2-bit address): key register at address 0, control register at address 1, status register at address 2. Address 3 and the key register read as 0x00.

Top module: `wdog_ctl`

## Requirements
- R1: After power-on reset (`rst_por_n` low), the control and status registers and the key register read 0x00, and `wd_rst` and `osc_run` are low.
- R2: A control write is accepted only if it falls on one of the 4 system clock cycles after the cycle in which the second key byte was written. Later control writes are ignored, and so are control writes made without the unlock, leaving the readback unchanged.
- R3: The unlock requires 0xA5 followed on the very next bus cycle by 0x3C, both written to address 0. A gap, the reverse order, or another bus write between them opens no window. One window admits only one control write.
- R4: Control bit 7 is the run enable. It reads back as written, and `osc_run` follows it.
- R5: Control bit 0 is a restart strobe that always reads back as 0. Writing it while enabled zeroes the counter, which then counts again from zero.
- R6: With the watchdog enabled, the counter wraps 65536 slow clock cycles after it was last zeroed. Measured at the ports from the restart write to the rise of `wd_rst`, counting both synchronizer paths, this is between 65538 and 65544 slow clock cycles. No reset occurs earlier.
- R7: Each watchdog reset pulse on `wd_rst` is high for exactly 4 system clock cycles.
- R8: The run enable reads 0 and `osc_run` is low after a watchdog reset and after a power-on reset.
- R9: Status bit 0 is set by a watchdog reset and is kept through that reset. Writing 0 to it clears it, and writing 1 to it has no effect. The status register needs no unlock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock |
| rst_por_n | input | 1 | Power-on / external hardware reset, active low, asynchronous |
| clk_wd | input | 1 | Slow watchdog clock from the dedicated oscillator |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| osc_run | output | 1 | Enable for the slow oscillator (mirrors the run enable) |
| wd_rst | output | 1 | Watchdog reset pulse to the system reset logic |

## Verification
Read data is combinational from the address, and a register write appears at the readback one system clock after the edge that captures it. The bench therefore drives each write at a falling edge and reads back at the next falling edge. The overflow reset is due 65536 slow cycles after the restart lands, plus the two synchronizer paths. The bench counts slow clock edges from the falling edge before the restart write until `wd_rst` is seen high, and accepts a window that covers only that latency. The slow clock has a 12 ns period offset by 3 ns, so its edges never coincide with a system edge. The pulse width is counted in system falling edges from its first sighting. Each "ignored" case is judged by reading the control register back before the next accepted write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int unsigned BUS_W  = 8;
   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_KEY  = 2'd0,
      REG_CTRL = 2'd1,
      REG_STAT = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   localparam logic [BUS_W-1:0] KEY_FIRST  = 8'hA5;
   localparam logic [BUS_W-1:0] KEY_SECOND = 8'h3C;

   localparam int unsigned CTRL_EN_BIT   = 7;
   localparam int unsigned CTRL_KICK_BIT = 0;
   localparam int unsigned STAT_FLAG_BIT = 0;

   typedef struct packed {
      logic              wr;
      logic [ADDR_W-1:0] addr;
      logic [BUS_W-1:0]  data;
   } bus_req_t;
endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      assert (STAGES >= 2) else $error("wdog_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wdog_unlock.sv
module wdog_unlock
   import wdog_pkg::*;
#(
   parameter int unsigned      WINDOW = 4,
   parameter logic [BUS_W-1:0] KEY_A  = KEY_FIRST,
   parameter logic [BUS_W-1:0] KEY_B  = KEY_SECOND
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     flush,
   input  bus_req_t req,
   output logic     ctrl_ok
);
   localparam int unsigned WIN_W = $clog2(WINDOW + 1);

   initial begin
      assert (WINDOW >= 1) else $error("wdog_unlock: WINDOW must be at least 1");
      assert (KEY_A != KEY_B) else $error("wdog_unlock: keys must differ");
   end

   logic             armed;
   logic [WIN_W-1:0] win;
   logic             key_hit, ctrl_hit, second_ok;

   assign key_hit   = req.wr && (req.addr == REG_KEY);
   assign ctrl_hit  = req.wr && (req.addr == REG_CTRL);
   assign second_ok = key_hit && armed && (req.data == KEY_B);
   assign ctrl_ok   = ctrl_hit && (win != '0) && !flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         win   <= '0;
      end else if (flush) begin
         armed <= 1'b0;
         win   <= '0;
      end else begin
         // armed only for the single cycle after the first key
         armed <= key_hit && (req.data == KEY_A);
         if (second_ok)                     win <= WIN_W'(WINDOW);
         else if (ctrl_hit && win != '0)    win <= '0;
         else if (win != '0)                win <= win - 1'b1;
      end
   end

   // R3: a window can only open right after an armed cycle
   assert_open_after_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (win != '0 && $past(win) == '0) |-> $past(armed));

   // R3: one accepted control write closes the window
   assert_single_use_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_ok && !second_ok) |=> (win == '0));
endmodule

// File: rtl/wdog_slow.sv
module wdog_slow #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned SYNC  = 2
) (
   input  logic clk_wd,
   input  logic rst_n,
   input  logic run_en,
   input  logic kick_tgl,
   output logic ovf_tgl
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   initial begin
      assert (CNT_W >= 2) else $error("wdog_slow: CNT_W must be at least 2");
   end

   logic             en_s, kick_s, kick_d, clr_evt;
   logic [CNT_W-1:0] cnt;

   wdog_sync #(.STAGES(SYNC)) u_en_sync (
      .clk(clk_wd), .rst_n(rst_n), .d(run_en), .q(en_s));

   wdog_sync #(.STAGES(SYNC)) u_kick_sync (
      .clk(clk_wd), .rst_n(rst_n), .d(kick_tgl), .q(kick_s));

   assign clr_evt = kick_s ^ kick_d;

   always_ff @(posedge clk_wd or negedge rst_n) begin
      if (!rst_n) begin
         kick_d  <= 1'b0;
         cnt     <= '0;
         ovf_tgl <= 1'b0;
      end else begin
         kick_d <= kick_s;
         if (!en_s || clr_evt) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_MAX) ovf_tgl <= ~ovf_tgl;
         end
      end
   end

   // R5: a restart that lands while enabled leaves the counter at zero
   assert_kick_zeroes_R5: assert property (@(posedge clk_wd) disable iff (!rst_n)
      (en_s && clr_evt) |=> (cnt == '0));

   // R6: reaching all ones while counting produces exactly one overflow event
   assert_wrap_event_R6: assert property (@(posedge clk_wd) disable iff (!rst_n)
      (en_s && !clr_evt && cnt == CNT_MAX) |=> (ovf_tgl != $past(ovf_tgl)));

   // R6: the counter does not advance while disabled
   assert_held_off_R6: assert property (@(posedge clk_wd) disable iff (!rst_n)
      !en_s |=> (cnt == '0));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned STRETCH = 4,
   parameter int unsigned WINDOW  = 4,
   parameter int unsigned SYNC    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bus_req_t         req,
   input  logic             ovf_tgl,
   output logic             run_en,
   output logic             kick_tgl,
   output logic             wd_rst,
   output logic [BUS_W-1:0] rdata
);
   localparam int unsigned ST_W = $clog2(STRETCH + 1);

   initial begin
      assert (STRETCH >= 1) else $error("wdog_regs: STRETCH must be at least 1");
   end

   logic            ovf_s, ovf_d, ovf_evt;
   logic [ST_W-1:0] st_cnt;
   logic            in_rst, flush, ctrl_ok, stat_wr, wd_flag;

   wdog_sync #(.STAGES(SYNC)) u_ovf_sync (
      .clk(clk), .rst_n(rst_n), .d(ovf_tgl), .q(ovf_s));

   assign ovf_evt = ovf_s ^ ovf_d;
   assign in_rst  = (st_cnt != '0);
   assign flush   = in_rst || ovf_evt;
   assign stat_wr = req.wr && (req.addr == REG_STAT);
   assign wd_rst  = in_rst;

   wdog_unlock #(.WINDOW(WINDOW)) u_unlock (
      .clk(clk), .rst_n(rst_n), .flush(flush), .req(req), .ctrl_ok(ctrl_ok));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_d    <= 1'b0;
         st_cnt   <= '0;
         run_en   <= 1'b0;
         kick_tgl <= 1'b0;
         wd_flag  <= 1'b0;
      end else begin
         ovf_d <= ovf_s;
         if (ovf_evt)            st_cnt <= ST_W'(STRETCH);
         else if (st_cnt != '0)  st_cnt <= st_cnt - 1'b1;

         if (ovf_evt) begin
            run_en <= 1'b0;
         end else if (ctrl_ok) begin
            run_en <= req.data[CTRL_EN_BIT];
            if (req.data[CTRL_KICK_BIT]) kick_tgl <= ~kick_tgl;
         end

         if (ovf_evt)
            wd_flag <= 1'b1;
         else if (stat_wr && !in_rst && !req.data[STAT_FLAG_BIT])
            wd_flag <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      case (reg_sel_e'(req.addr))
         REG_CTRL: rdata[CTRL_EN_BIT]   = run_en;
         REG_STAT: rdata[STAT_FLAG_BIT] = wd_flag;
         default:  rdata = '0;
      endcase
   end

   // checker counter for the pulse width
   logic [ST_W:0] hi_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hi_len <= '0;
      else if (!wd_rst) hi_len <= '0;
      else if (hi_len != '1) hi_len <= hi_len + 1'b1;
   end

   // R7: the reset pulse lasts exactly STRETCH cycles
   assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_rst) |-> (hi_len == (ST_W+1)'(STRETCH)));

   // R8: the run enable is already down when the reset pulse starts
   assert_en_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_rst) |-> !run_en);

   // R9: the cause flag is set when the pulse starts and survives it
   assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_rst) |-> wd_flag);
   assert_flag_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_rst && wd_flag) |=> wd_flag);

   // R2: the run enable rises only through an accepted control write
   assert_en_needs_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_en) |-> $past(ctrl_ok));
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
   import wdog_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned STRETCH     = 4,
   parameter int unsigned WINDOW      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_sys,
   input  logic              rst_por_n,
   input  logic              clk_wd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              osc_run,
   output logic              wd_rst
);
   bus_req_t req;
   logic     run_en, kick_tgl, ovf_tgl;

   assign req.wr   = bus_wr;
   assign req.addr = bus_addr;
   assign req.data = bus_wdata;

   wdog_regs #(
      .STRETCH(STRETCH), .WINDOW(WINDOW), .SYNC(SYNC_STAGES)
   ) u_regs (
      .clk(clk_sys), .rst_n(rst_por_n), .req(req), .ovf_tgl(ovf_tgl),
      .run_en(run_en), .kick_tgl(kick_tgl), .wd_rst(wd_rst), .rdata(bus_rdata));

   wdog_slow #(
      .CNT_W(CNT_W), .SYNC(SYNC_STAGES)
   ) u_slow (
      .clk_wd(clk_wd), .rst_n(rst_por_n), .run_en(run_en),
      .kick_tgl(kick_tgl), .ovf_tgl(ovf_tgl));

   assign osc_run = run_en;
endmodule

// File: tb/wdog_ctl_test.sv
module wdog_ctl_test;
   logic       clk_sys = 1'b0, clk_wd = 1'b0, rst_por_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       osc_run, wd_rst;

   int tests_run = 0, tests_failed = 0;
   int unsigned slow_edges = 0;

   localparam logic [1:0] A_KEY = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2;

   wdog_ctl uut (
      .clk_sys(clk_sys), .rst_por_n(rst_por_n), .clk_wd(clk_wd),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .osc_run(osc_run), .wd_rst(wd_rst));

   always #4 clk_sys = ~clk_sys;           // 125 MHz
   initial begin #3; forever #6 clk_wd = ~clk_wd; end  // 12 ns, ratio 1.5
   always @(posedge clk_wd) slow_edges++;

   task automatic chk(string tag, int act, int exp);
      tests_run++;
      if (act != exp) begin
         tests_failed++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk_sys);
   endtask

   // called at a falling edge; back-to-back calls give consecutive bus cycles
   task automatic wr(logic [1:0] a, logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk_sys);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output int v);
      bus_addr = a; #1; v = int'(bus_rdata);
   endtask

   task automatic unlock();
      wr(A_KEY, 8'hA5); wr(A_KEY, 8'h3C);
   endtask

   task automatic por();
      rst_por_n = 1'b0; idle(3); rst_por_n = 1'b1; idle(2);
   endtask

   task automatic t_reset();
      int v;
      por();
      rd(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
      rd(A_STAT, v); chk("R1 status", v, 8'h00);
      rd(A_KEY, v);  chk("R1 key", v, 8'h00);
      chk("R1 wd_rst", int'(wd_rst), 0);
      chk("R1 osc_run", int'(osc_run), 0);
   endtask

   task automatic t_enable();
      int v;
      por();
      unlock(); wr(A_CTRL, 8'h80);
      rd(A_CTRL, v); chk("R4 enable readback", v, 8'h80);
      chk("R4 osc_run on", int'(osc_run), 1);
      por();
      rd(A_CTRL, v); chk("R8 enable after por", v, 8'h00);
      chk("R8 osc_run after por", int'(osc_run), 0);
   endtask

   task automatic t_window();
      int v;
      por();
      unlock(); idle(3); wr(A_CTRL, 8'h80);
      rd(A_CTRL, v); chk("R2 write on 4th cycle", v, 8'h80);
      unlock(); idle(4); wr(A_CTRL, 8'h00);
      rd(A_CTRL, v); chk("R2 write on 5th cycle ignored", v, 8'h80);
      wr(A_CTRL, 8'h00);
      rd(A_CTRL, v); chk("R2 write without unlock ignored", v, 8'h80);
      unlock(); wr(A_CTRL, 8'h00);
      rd(A_CTRL, v); chk("R2 write on 1st cycle", v, 8'h00);
   endtask

   task automatic t_sequence();
      int v;
      por();
      wr(A_KEY, 8'hA5); idle(1); wr(A_KEY, 8'h3C); wr(A_CTRL, 8'h80);
      rd(A_CTRL, v); chk("R3 gap between keys", v, 8'h00);
      wr(A_KEY, 8'h3C); wr(A_KEY, 8'hA5); wr(A_CTRL, 8'h80);
      rd(A_CTRL, v); chk("R3 reversed keys", v, 8'h00);
      wr(A_KEY, 8'hA5); wr(A_STAT, 8'h00); wr(A_KEY, 8'h3C); wr(A_CTRL, 8'h80);
      rd(A_CTRL, v); chk("R3 interrupted keys", v, 8'h00);
      unlock(); wr(A_CTRL, 8'h80); wr(A_CTRL, 8'h00);
      rd(A_CTRL, v); chk("R3 one write per unlock", v, 8'h80);
   endtask

   task automatic t_kick_read();
      int v;
      por();
      unlock(); wr(A_CTRL, 8'h81);
      rd(A_CTRL, v); chk("R5 kick reads 0", v, 8'h80);
   endtask

   task automatic t_overflow();
      int v, w, guard;
      int unsigned s0, el;
      por();
      unlock(); wr(A_CTRL, 8'h80);
      idle(4000);
      unlock();
      s0 = slow_edges;
      wr(A_CTRL, 8'h81);            // restart; R5 moves the deadline here
      guard = 0;
      while (!wd_rst && guard < 150000) begin
         @(negedge clk_sys); guard++;
      end
      el = slow_edges - s0;
      tests_run++;
      if (el < 65538 || el > 65544) begin
         tests_failed++;
         $display("FAIL R6/R5: actual %0d slow cycles expected 65538..65544", el);
      end
      rd(A_CTRL, v); chk("R8 enable during pulse", v, 8'h00);
      w = 0;
      while (wd_rst && w < 100) begin
         w++; @(negedge clk_sys);
      end
      chk("R7 pulse width", w, 4);
      rd(A_CTRL, v); chk("R8 enable after wd reset", v, 8'h00);
      chk("R8 osc_run after wd reset", int'(osc_run), 0);
      rd(A_STAT, v); chk("R9 flag set", v, 8'h01);
      wr(A_STAT, 8'hFF);
      rd(A_STAT, v); chk("R9 write 1 no effect", v, 8'h01);
      wr(A_STAT, 8'h00);
      rd(A_STAT, v); chk("R9 write 0 clears", v, 8'h00);
   endtask

   initial begin
      repeat (180000) @(posedge clk_sys);
      tests_run++; tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end

   initial begin
      @(negedge clk_sys);
      t_reset();
      t_enable();
      t_window();
      t_sequence();
      t_kick_read();
      t_overflow();
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
   end
endmodule